// File: doc/BRIEF.md
# Octal DAC Command Decoder and Register Control

This block sits behind a serial deserializer that presents each 24-bit command frame as a single word with a one-cycle valid strobe. It decodes every frame and maintains the control state of an eight-channel DAC. That state is a staged input code and a live output code for each channel, a fallback value for each channel, two configuration bits for each channel (clear-protect and gate-exempt), a power-up bitmap, the global reference mode and its power policy, and a software gate flag. Four of the commands are accepted only when all 24 bits equal one exact value. Any frame that matches nothing is dropped without effect.

The block drives the code for each channel toward the converters and an enable for the internal reference. While the gate flag is set, each channel that is not gate-exempt shows its fallback value. Its stored codes go on updating in the background. A lockout input from an external watchdog blocks reference changes. The bit width of a channel code, the channel count, the reset fallback value and the choice between a combinational and a registered output stage are parameters.

Top module: `dacctl_top`

## Requirements
- R1: After a synchronous active-high reset, every channel output is 0, `ref_mode` is 00 (external), `ref_pwr_en` is 0 and `gate_on` is 0. All channels are powered up, and every configuration bit is 0.
- R2: A frame with B[23:20]=0010 sets the reference mode from B[17:16] (00 external, 01 2.5 V, 10 2.0 V, 11 4.0 V) and the power-hold bit from B18. Bits B19 and B[15:0] have no effect.
- R3: `ref_pwr_en` is 1 exactly when the mode is not 00 and either at least one channel is powered up or the power-hold bit is 1.
- R4: A reference frame has no effect while `ref_lock` is 1.
- R5: Frame 0x319630 sets the gate flag and frame 0x309630 clears it. While the flag is set, a channel whose gate-exempt bit is 0 outputs its fallback value, and a channel whose gate-exempt bit is 1 outputs its live code.
- R6: Setting or clearing the gate flag leaves the staged and live codes unchanged. Code writes made while gated take effect and appear once the gate is cleared.
- R7: Frame 0x349630 copies the fallback value into the staged and live codes of every channel whose clear-protect bit is 0. All other channels are left unchanged.
- R8: Frame 0x359630 returns all codes, fallback values, configuration bits, the power bitmap, the reference register and the gate flag to their reset values.
- R9: A frame that matches no command has no effect. This includes a magic value with any single bit flipped into an unused encoding, a nibble 0011 frame that is not exact, and any data presented while `frame_vld` is 0.
- R10: Channel commands take the channel from B[18:16] and the code from B[15:4]. B[23:20]=1000 writes the staged code. 1001 copies the staged code into the live code. 1010 writes both. 0110 writes the fallback value. 0100 loads the power bitmap from B[15:8] (1 = up). 0101 sets the gate-exempt bit from B1 and the clear-protect bit from B0 on every channel selected in the mask B[15:8]. Each takes effect on the clock edge where `frame_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe marking a complete frame |
| frame_data | input | 24 | Command frame, bit 23 first field |
| ref_lock | input | 1 | Watchdog lockout; blocks reference commands |
| ch_out | output | N*DW (96) | Effective code per channel, channel 0 in the low bits |
| ref_mode | output | 2 | Current reference mode |
| ref_pwr_en | output | 1 | Internal reference power enable |
| gate_on | output | 1 | Software gate flag |

## Verification
The assertions assume that `frame_vld` stays low for at least one cycle between frames and that `frame_data` is stable while it is high. The stability checks on stored codes rely on this. They also assume that `ref_lock` changes only between frames. The stimulus drives every frame for one cycle at the falling edge, follows it with an idle cycle, and moves `ref_lock` only in those idle gaps. Reset is applied only at the start. The software reset command is the only other way the registers return to their reset values.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_REF,
      OP_GSET,
      OP_GCLR,
      OP_SWCLR,
      OP_SWRST,
      OP_CODE,
      OP_LOAD,
      OP_CODELOAD,
      OP_DFLT,
      OP_CFG,
      OP_PWR
   } op_e;

   // exact-match control frames
   localparam logic [23:0] MAGIC_GCLR  = 24'h309630;
   localparam logic [23:0] MAGIC_GSET  = 24'h319630;
   localparam logic [23:0] MAGIC_SWCLR = 24'h349630;
   localparam logic [23:0] MAGIC_SWRST = 24'h359630;

   // top-nibble command classes
   localparam logic [3:0] NIB_REF      = 4'h2;
   localparam logic [3:0] NIB_PWR      = 4'h4;
   localparam logic [3:0] NIB_CFG      = 4'h5;
   localparam logic [3:0] NIB_DFLT     = 4'h6;
   localparam logic [3:0] NIB_CODE     = 4'h8;
   localparam logic [3:0] NIB_LOAD     = 4'h9;
   localparam logic [3:0] NIB_CODELOAD = 4'hA;

   localparam int FRAME_W = 24;
   localparam int FIELD_W = 16;

endpackage

// File: rtl/dacctl_decode.sv
module dacctl_decode
   import dacctl_pkg::*;
#(
   parameter int CH_W = 3
) (
   input  logic               frame_vld,
   input  logic [FRAME_W-1:0] frame_data,
   output op_e                op,
   output logic [CH_W-1:0]    ch_idx,
   output logic [FIELD_W-1:0] field
);

   logic [3:0] nib;

   assign nib    = frame_data[23:20];
   assign ch_idx = frame_data[16 +: CH_W];
   assign field  = frame_data[FIELD_W-1:0];

   always_comb begin
      op = OP_NONE;
      if (frame_vld) begin
         if (frame_data == MAGIC_GCLR)       op = OP_GCLR;
         else if (frame_data == MAGIC_GSET)  op = OP_GSET;
         else if (frame_data == MAGIC_SWCLR) op = OP_SWCLR;
         else if (frame_data == MAGIC_SWRST) op = OP_SWRST;
         else begin
            unique case (nib)
               NIB_REF:      op = OP_REF;
               NIB_PWR:      op = OP_PWR;
               NIB_CFG:      op = OP_CFG;
               NIB_DFLT:     op = OP_DFLT;
               NIB_CODE:     op = OP_CODE;
               NIB_LOAD:     op = OP_LOAD;
               NIB_CODELOAD: op = OP_CODELOAD;
               default:      op = OP_NONE;
            endcase
         end
      end
   end

endmodule

// File: rtl/dacctl_ref.sv
module dacctl_ref
   import dacctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  op_e        op,
   input  logic [1:0] mode_i,
   input  logic       hold_i,
   input  logic       lock,
   input  logic       any_pwr,
   output logic [1:0] mode_o,
   output logic       hold_o,
   output logic       pwr_en_o
);

   logic [1:0] mode_q;
   logic       hold_q;

   always_ff @(posedge clk) begin
      if (rst || op == OP_SWRST) begin
         mode_q <= 2'b00;
         hold_q <= 1'b0;
      end else if (op == OP_REF && !lock) begin
         mode_q <= mode_i;
         hold_q <= hold_i;
      end
   end

   assign mode_o   = mode_q;
   assign hold_o   = hold_q;
   assign pwr_en_o = (mode_q != 2'b00) && (any_pwr || hold_q);

   assert_ref_load_R2: assert property (@(posedge clk) disable iff (rst)
      (op == OP_REF && !lock) |=> (mode_q == $past(mode_i) && hold_q == $past(hold_i)));

   assert_ref_locked_R4: assert property (@(posedge clk) disable iff (rst)
      (op == OP_REF && lock) |=> ($stable(mode_q) && $stable(hold_q)));

endmodule

// File: rtl/dacctl_chan.sv
module dacctl_chan
   import dacctl_pkg::*;
#(
   parameter int          DW       = 12,
   parameter logic [DW-1:0] DFLT_RST = '0,
   parameter bit          OUT_REG  = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  op_e           op,
   input  logic          sel,
   input  logic          cfg_sel,
   input  logic [DW-1:0] data,
   input  logic          cfg_gtb,
   input  logic          cfg_clb,
   input  logic          gate,
   output logic [DW-1:0] out
);

   logic [DW-1:0] code_q;
   logic [DW-1:0] dac_q;
   logic [DW-1:0] dflt_q;
   logic          gtb_q;
   logic          clb_q;
   logic [DW-1:0] eff;

   always_ff @(posedge clk) begin
      if (rst || op == OP_SWRST) begin
         code_q <= '0;
         dac_q  <= '0;
         dflt_q <= DFLT_RST;
         gtb_q  <= 1'b0;
         clb_q  <= 1'b0;
      end else begin
         case (op)
            OP_CODE:     if (sel) code_q <= data;
            OP_LOAD:     if (sel) dac_q <= code_q;
            OP_CODELOAD: if (sel) begin
               code_q <= data;
               dac_q  <= data;
            end
            OP_DFLT:     if (sel) dflt_q <= data;
            OP_CFG:      if (cfg_sel) begin
               gtb_q <= cfg_gtb;
               clb_q <= cfg_clb;
            end
            OP_SWCLR:    if (!clb_q) begin
               code_q <= dflt_q;
               dac_q  <= dflt_q;
            end
            default: ;
         endcase
      end
   end

   assign eff = (gate && !gtb_q) ? dflt_q : dac_q;

   generate
      if (OUT_REG) begin : g_out_reg
         logic [DW-1:0] out_q;
         always_ff @(posedge clk) begin
            if (rst) out_q <= '0;
            else     out_q <= eff;
         end
         assign out = out_q;
      end else begin : g_out_comb
         assign out = eff;
      end
   endgenerate

   assert_gate_keeps_codes_R6: assert property (@(posedge clk) disable iff (rst)
      (op == OP_GSET || op == OP_GCLR) |=> ($stable(code_q) && $stable(dac_q)));

   assert_clear_protect_R7: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SWCLR && clb_q) |=> ($stable(code_q) && $stable(dac_q)));

   assert_clear_loads_R7: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SWCLR && !clb_q) |=> (code_q == $past(dflt_q) && dac_q == $past(dflt_q)));

endmodule

// File: rtl/dacctl_top.sv
module dacctl_top
   import dacctl_pkg::*;
#(
   parameter int            N        = 8,
   parameter int            DW       = 12,
   parameter logic [DW-1:0] DFLT_RST = '0,
   parameter bit            OUT_REG  = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            frame_vld,
   input  logic [23:0]     frame_data,
   input  logic            ref_lock,
   output logic [N*DW-1:0] ch_out,
   output logic [1:0]      ref_mode,
   output logic            ref_pwr_en,
   output logic            gate_on
);

   localparam int CH_W = 3;
   localparam int LSB  = FIELD_W - DW;

   generate
      if (N < 1 || N > 8) begin : g_bad_n
         $error("dacctl_top: N must be 1..8");
      end
      if (DW < 1 || DW > 12) begin : g_bad_dw
         $error("dacctl_top: DW must be 1..12");
      end
   endgenerate

   op_e                dec_op;
   logic [CH_W-1:0]    dec_ch;
   logic [FIELD_W-1:0] dec_field;
   logic               gate_q;
   logic [N-1:0]       pwr_q;
   logic               hold;

   dacctl_decode #(.CH_W(CH_W)) u_dec (
      .frame_vld  (frame_vld),
      .frame_data (frame_data),
      .op         (dec_op),
      .ch_idx     (dec_ch),
      .field      (dec_field)
   );

   always_ff @(posedge clk) begin
      if (rst || dec_op == OP_SWRST) begin
         gate_q <= 1'b0;
         pwr_q  <= '1;
      end else begin
         if (dec_op == OP_GSET) gate_q <= 1'b1;
         if (dec_op == OP_GCLR) gate_q <= 1'b0;
         if (dec_op == OP_PWR)  pwr_q  <= dec_field[8 +: N];
      end
   end

   dacctl_ref u_ref (
      .clk      (clk),
      .rst      (rst),
      .op       (dec_op),
      .mode_i   (frame_data[17:16]),
      .hold_i   (frame_data[18]),
      .lock     (ref_lock),
      .any_pwr  (|pwr_q),
      .mode_o   (ref_mode),
      .hold_o   (hold),
      .pwr_en_o (ref_pwr_en)
   );

   generate
      for (genvar i = 0; i < N; i++) begin : g_ch
         dacctl_chan #(
            .DW       (DW),
            .DFLT_RST (DFLT_RST),
            .OUT_REG  (OUT_REG)
         ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .op      (dec_op),
            .sel     (dec_ch == CH_W'(i)),
            .cfg_sel (dec_field[8 + i]),
            .data    (dec_field[FIELD_W-1:LSB]),
            .cfg_gtb (dec_field[1]),
            .cfg_clb (dec_field[0]),
            .gate    (gate_q),
            .out     (ch_out[i*DW +: DW])
         );
      end
   endgenerate

   assign gate_on = gate_q;

   assert_pwr_needs_internal_R3: assert property (@(posedge clk) disable iff (rst)
      (ref_mode == 2'b00) |-> !ref_pwr_en);

   assert_pwr_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (ref_mode != 2'b00 && hold) |-> ref_pwr_en);

   assert_gate_cmd_R5: assert property (@(posedge clk) disable iff (rst)
      (dec_op == OP_GSET) |=> gate_on);

   assert_nop_stable_R9: assert property (@(posedge clk) disable iff (rst)
      (dec_op == OP_NONE) |=> ($stable(gate_q) && $stable(pwr_q) && $stable(ref_mode)));

   assert_swrst_R8: assert property (@(posedge clk) disable iff (rst)
      (dec_op == OP_SWRST) |=> (!gate_q && ref_mode == 2'b00 && (&pwr_q)));

endmodule

// File: tb/dacctl_top_tb.sv
`timescale 1ns/1ps
module dacctl_top_tb;

   localparam int N  = 8;
   localparam int DW = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          frame_vld = 1'b0;
   logic [23:0]   frame_data = '0;
   logic          ref_lock = 1'b0;
   logic [N*DW-1:0] ch_out;
   logic [1:0]    ref_mode;
   logic          ref_pwr_en;
   logic          gate_on;

   int total = 0;
   int bad   = 0;

   // bench model of requirement-level state
   logic [DW-1:0] m_code [N];
   logic [DW-1:0] m_dac  [N];
   logic [DW-1:0] m_dflt [N];
   logic [N-1:0]  m_gtb, m_clb, m_pwr;
   logic [1:0]    m_mode;
   logic          m_hold, m_gate;

   always #4 clk = ~clk;

   dacctl_top u_dut (
      .clk        (clk),
      .rst        (rst),
      .frame_vld  (frame_vld),
      .frame_data (frame_data),
      .ref_lock   (ref_lock),
      .ch_out     (ch_out),
      .ref_mode   (ref_mode),
      .ref_pwr_en (ref_pwr_en),
      .gate_on    (gate_on)
   );

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         m_code[i] = '0; m_dac[i] = '0; m_dflt[i] = '0;
      end
      m_gtb = '0; m_clb = '0; m_pwr = '1;
      m_mode = 2'b00; m_hold = 1'b0; m_gate = 1'b0;
   endtask

   task automatic model_apply(input logic [23:0] f);
      int c;
      c = int'(f[18:16]);
      if (f == 24'h309630) m_gate = 1'b0;
      else if (f == 24'h319630) m_gate = 1'b1;
      else if (f == 24'h349630) begin
         for (int i = 0; i < N; i++)
            if (!m_clb[i]) begin m_code[i] = m_dflt[i]; m_dac[i] = m_dflt[i]; end
      end else if (f == 24'h359630) model_reset();
      else begin
         case (f[23:20])
            4'h2: if (!ref_lock) begin m_mode = f[17:16]; m_hold = f[18]; end
            4'h4: m_pwr = f[15:8];
            4'h5: for (int i = 0; i < N; i++)
                     if (f[8+i]) begin m_gtb[i] = f[1]; m_clb[i] = f[0]; end
            4'h6: m_dflt[c] = f[15:4];
            4'h8: m_code[c] = f[15:4];
            4'h9: m_dac[c] = m_code[c];
            4'hA: begin m_code[c] = f[15:4]; m_dac[c] = f[15:4]; end
            default: ;
         endcase
      end
   endtask

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < N; i++) begin
         int e;
         e = (m_gate && !m_gtb[i]) ? int'(m_dflt[i]) : int'(m_dac[i]);
         chk(tag, $sformatf("ch%0d", i), int'(ch_out[i*DW +: DW]), e);
      end
      chk(tag, "ref_mode", int'(ref_mode), int'(m_mode));
      chk(tag, "ref_pwr_en", int'(ref_pwr_en),
          int'((m_mode != 2'b00) && ((|m_pwr) || m_hold)));
      chk(tag, "gate_on", int'(gate_on), int'(m_gate));
   endtask

   task automatic send(input logic [23:0] f, input string tag);
      @(negedge clk);
      frame_vld  = 1'b1;
      frame_data = f;
      @(negedge clk);
      frame_vld  = 1'b0;
      model_apply(f);
      check_all(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [23:0] magic [5];
      magic[0] = 24'h309630; magic[1] = 24'h319630; magic[2] = 24'h349630;
      magic[3] = 24'h359630; magic[4] = 24'h329630;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_all("R1");

      // R10: fallback, staged, live codes per channel
      for (int i = 0; i < N; i++)
         send({4'h6, 1'b0, 3'(i), 12'(i*291 + 17), 4'h0}, "R10");
      for (int i = 0; i < N; i++) begin
         send({4'h8, 1'b0, 3'(i), 12'(4095 - i*333), 4'h5}, "R10");
         send({4'h9, 1'b1, 3'(i), 16'hFFFF}, "R10");
         send({4'hA, 1'b0, 3'((i+3)%N), 12'(i*111 + 1), 4'h0}, "R10");
      end
      send(24'h400000 | (24'h5A << 8), "R10");
      send(24'h500000 | (24'hC3 << 8) | 24'h3, "R10");

      // R2 / R3: every mode and hold value, with powered and unpowered channels
      for (int p = 0; p < 2; p++) begin
         send(p == 0 ? 24'h40FF00 : 24'h400000, "R3");
         for (int m = 0; m < 8; m++)
            send({4'h2, 1'(m % 2), 3'(m), 16'(m*4097 + 3)}, "R2");
      end
      send(24'h40FF00, "R3");

      // R4: lockout blocks reference frames
      @(negedge clk); ref_lock = 1'b1;
      for (int m = 0; m < 4; m++)
         send({4'h2, 2'b01, 2'(m), 16'h1234}, "R4");
      @(negedge clk); ref_lock = 1'b0;
      send(24'h230000, "R4");

      // R5 / R6: gate, mixed exempt bits, writes while gated
      send(24'h319630, "R5");
      for (int i = 0; i < N; i++)
         send({4'hA, 1'b0, 3'(i), 12'(i*500 + 7), 4'h0}, "R6");
      send(24'h500000 | (24'h0F << 8) | 24'h2, "R5");
      send(24'h309630, "R6");

      // R9: single-bit corruptions of magic frames, strobe low, nibble 3 junk
      for (int k = 0; k < 5; k++)
         for (int b = 0; b < 24; b++)
            send(magic[k] ^ (24'h1 << b), "R9");
      send(24'h3FFFFF, "R9");
      send(24'hF12345, "R9");
      @(negedge clk);
      frame_data = 24'h319630;
      @(negedge clk);
      frame_data = 24'hA0FFF0;
      @(negedge clk);
      check_all("R9");

      // R7: clear with mixed protection
      send(24'h500000 | (24'hFF << 8) | 24'h0, "R7");
      send(24'h500000 | (24'hA5 << 8) | 24'h1, "R7");
      for (int i = 0; i < N; i++)
         send({4'hA, 1'b0, 3'(i), 12'(3000 - i*77), 4'h0}, "R7");
      send(24'h349630, "R7");

      // R8: software reset after loading state
      send(24'h319630, "R8");
      send(24'h260000, "R8");
      send(24'h359630, "R8");
      send(24'h350000, "R8");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule